// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the add/subtract slice of a 32-bit integer execution path. A single carry-propagate adder serves ten operations. Five are add forms, and five are the matching subtract-from forms, which take the second operand minus the first. Each operation can feed in a constant carry or the stored carry flag. The result and a 4-bit condition field leave the block combinationally in the same cycle the operands arrive.

The block keeps three status flags in registers: carry (CA), overflow (OV) and a sticky summary overflow (SO). An operation changes them only when the issue strobe is high at a clock edge. A separate clear command zeroes all three flags at once. A per-operation "record overflow" bit chooses whether the operation writes OV and SO at all. Carry means no-borrow for the subtract forms, so a multi-word subtraction can be chained through CA just like a multi-word addition.

Top module: `addsub_xer_unit`

## Requirements
- R1: `op_code[3]=0` selects an add form, and `op_code[2:0]` selects the variant. 0 gives A+B and 1 gives A+B. 2 gives A+B+CA. 3 gives A+CA−1, with B ignored. 4 gives A+CA, with B ignored. Codes 5 to 7 behave as code 0. All results wrap modulo 2^32.
- R2: `op_code[3]=1` selects the subtract-from forms, using the same variant codes. 0 and 1 give B−A, computed as B+~A+1. 2 gives B+~A+CA. 3 gives ~A+CA−1. 4 gives ~A+CA. Codes 5 to 7 behave as code 0.
- R3: Variants 1 to 4 write CA with the carry out of the 32-bit sum. For a plain add this means CA=1 exactly when the wrapped sum is below A. For a plain subtract it means CA=1 exactly when the result is not above B (unsigned). In the carry-in forms, CA is also 1 when the incoming CA is 1 and the sum equals the first addend.
- R4: Variant 0 and variants 5 to 7 leave CA unchanged.
- R5: When `op_record_ov`=1, signed overflow sets both OV and SO. Signed overflow means the two adder inputs share a sign and the result's sign differs from it.
- R6: When `op_record_ov`=1 and there is no signed overflow, OV is cleared and SO keeps its value.
- R7: When `op_record_ov`=0, OV and SO are left unchanged.
- R8: The flags change only at a rising clock edge where `op_valid` or `flag_clear` is high. Otherwise they hold.
- R9: `flag_clear` zeroes CA, OV and SO at the next edge, and it takes priority over `op_valid`.
- R10: The condition field is `rec_field`. Bit 3 is set for a negative result, bit 2 for a positive result and bit 1 for a zero result. Bit 0 carries the OV value the current operation would leave: the new OV in recording forms, otherwise the stored OV.
- R11: An active-low reset clears CA, OV and SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe; flags update at the edge when high |
| op_code | input | 4 | Bit 3 selects subtract-from; bits 2:0 select the variant |
| op_record_ov | input | 1 | Operation writes OV and SO |
| flag_clear | input | 1 | Zero all flags at the next edge |
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| result | output | 32 | Combinational result |
| rec_field | output | 4 | Condition field: negative, positive, zero, overflow |
| flag_ca | output | 1 | Registered carry flag |
| flag_ov | output | 1 | Registered overflow flag |
| flag_so | output | 1 | Registered sticky summary overflow |

## Verification
The bench targets the following corner cases:

- **Carry-in with an all-ones or zero operand.** In these cases the sum equals the first operand with CA=1. A design that set carry from the comparison alone would report CA=0 here.
- **Subtraction with equal operands and with A=0.** A design that treated carry as borrow would invert CA in these cases.
- **The four extreme overflow points.** These are A=0x80000000 into the minus-one form, 0x7FFFFFFF into the zero form, and their subtract-from mirrors. A design that checked overflow on A and B instead of on the actual adder inputs would miss every one of them.
- **Sticky and priority behaviour.** The bench runs a recording op without overflow after one with overflow; a non-sticky SO would drop to zero. It also runs non-recording ops and reserved variant codes, which must leave OV, SO and CA untouched. Finally it asserts clear together with an overflowing issue, where a design with the wrong priority would leave flags set.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int OPC_W = 4;
    localparam int REC_W = 4;

    // variant selected by op_code[2:0]
    typedef enum logic [2:0] {
        VAR_BASIC  = 3'd0,
        VAR_CARRY  = 3'd1,
        VAR_EXTEND = 3'd2,
        VAR_MINUS1 = 3'd3,
        VAR_ZERO   = 3'd4
    } variant_e;

    // source of the second adder input
    typedef enum logic [1:0] {
        YSRC_B    = 2'd0,
        YSRC_ZERO = 2'd1,
        YSRC_ONES = 2'd2
    } ysrc_e;

    // source of the adder carry-in
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cinsel_e;

    typedef struct packed {
        logic    inv_a;
        ysrc_e   ysrc;
        cinsel_e cin;
        logic    wr_ca;
    } ctrl_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } flags_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
    import addsub_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output ctrl_t            ctrl
);

    variant_e var_sel;
    logic     is_sub;

    always_comb begin
        is_sub  = op_code[OPC_W-1];
        var_sel = variant_e'(op_code[2:0]);

        ctrl.inv_a = is_sub;
        ctrl.ysrc  = YSRC_B;
        ctrl.cin   = is_sub ? CIN_ONE : CIN_ZERO;
        ctrl.wr_ca = 1'b0;

        case (var_sel)
            VAR_CARRY: begin
                ctrl.wr_ca = 1'b1;
            end
            VAR_EXTEND: begin
                ctrl.cin   = CIN_FLAG;
                ctrl.wr_ca = 1'b1;
            end
            VAR_MINUS1: begin
                ctrl.ysrc  = YSRC_ONES;
                ctrl.cin   = CIN_FLAG;
                ctrl.wr_ca = 1'b1;
            end
            VAR_ZERO: begin
                ctrl.ysrc  = YSRC_ZERO;
                ctrl.cin   = CIN_FLAG;
                ctrl.wr_ca = 1'b1;
            end
            default: begin
                // basic form and reserved codes: no carry write
                ctrl.wr_ca = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             ca_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             sgn_ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_c;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        add_x = ctrl.inv_a ? ~opnd_a : opnd_a;

        case (ctrl.ysrc)
            YSRC_ZERO: add_y = '0;
            YSRC_ONES: add_y = '1;
            default:   add_y = opnd_b;
        endcase

        case (ctrl.cin)
            CIN_ONE:  add_c = 1'b1;
            CIN_FLAG: add_c = ca_in;
            default:  add_c = 1'b0;
        endcase

        wide_sum  = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_c};
        sum       = wide_sum[MSB:0];
        carry_out = wide_sum[WIDTH];
        // same-signed inputs whose result has the other sign
        sgn_ovf   = (add_x[MSB] == add_y[MSB]) && (wide_sum[MSB] != add_x[MSB]);
    end

endmodule

// File: rtl/addsub_cond.sv
module addsub_cond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             ov_bit,
    output logic [REC_W-1:0] rec_field
);

    localparam int MSB = WIDTH - 1;

    logic is_zero;

    always_comb begin
        is_zero   = (value == '0);
        rec_field = {value[MSB], !value[MSB] && !is_zero, is_zero, ov_bit};
    end

endmodule

// File: rtl/addsub_xer_unit.sv
module addsub_xer_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             op_record_ov,
    input  logic             flag_clear,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       rec_field,
    output logic             flag_ca,
    output logic             flag_ov,
    output logic             flag_so
);

    ctrl_t            ctrl;
    flags_t           flg_d;
    flags_t           flg_q;
    logic [WIDTH-1:0] sum;
    logic             carry_out;
    logic             sgn_ovf;
    logic             ov_eff;

    addsub_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .ctrl      (ctrl),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .ca_in     (flg_q.ca),
        .sum       (sum),
        .carry_out (carry_out),
        .sgn_ovf   (sgn_ovf)
    );

    addsub_cond #(.WIDTH(WIDTH)) u_cond (
        .value     (sum),
        .ov_bit    (ov_eff),
        .rec_field (rec_field)
    );

    always_comb begin
        ov_eff = op_record_ov ? sgn_ovf : flg_q.ov;
        flg_d  = flg_q;
        if (flag_clear) begin
            flg_d = '0;
        end else if (op_valid) begin
            if (ctrl.wr_ca) begin
                flg_d.ca = carry_out;
            end
            if (op_record_ov) begin
                flg_d.ov = sgn_ovf;
                flg_d.so = flg_q.so | sgn_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign result  = sum;
    assign flag_ca = flg_q.ca;
    assign flag_ov = flg_q.ov;
    assign flag_so = flg_q.so;

endmodule

// File: rtl/addsub_xer_chk.sv
module addsub_xer_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic             op_record_ov,
    input logic             flag_clear,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       rec_field,
    input logic             flag_ca,
    input logic             flag_ov,
    input logic             flag_so
);

    logic basic_var;
    assign basic_var = (op_code[2:0] == 3'd0) || (op_code[2:0] > 3'd4);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clear |=> (!flag_ca && !flag_ov && !flag_so));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_clear) |=> $stable({flag_ca, flag_ov, flag_so}));

    assert_norecord_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_clear && !op_record_ov) |=> $stable({flag_ov, flag_so}));

    assert_basic_keeps_ca_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_clear && basic_var) |=> $stable(flag_ca));

    assert_overflow_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_clear && op_record_ov && rec_field[0]) |=> (flag_ov && flag_so));

    assert_so_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_so && !flag_clear) |=> flag_so);

    assert_cond_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rec_field[3:1]) == 1);

    assert_cond_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_field[1] == (result == '0));

endmodule

bind addsub_xer_unit addsub_xer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .op_record_ov (op_record_ov),
    .flag_clear   (flag_clear),
    .result       (result),
    .rec_field    (rec_field),
    .flag_ca      (flag_ca),
    .flag_ov      (flag_ov),
    .flag_so      (flag_so)
);

// File: tb/addsub_xer_unit_test.sv
`timescale 1ns/1ps
module addsub_xer_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        op_record_ov = 1'b0;
    logic        flag_clear = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic [3:0]  rec_field;
    logic        flag_ca;
    logic        flag_ov;
    logic        flag_so;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    addsub_xer_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .op_record_ov (op_record_ov),
        .flag_clear   (flag_clear),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .result       (result),
        .rec_field    (rec_field),
        .flag_ca      (flag_ca),
        .flag_ov      (flag_ov),
        .flag_so      (flag_so)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        rec;
        logic        cin;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        ca;
        logic        ovf;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VT [NV] = '{
        {4'h0, 1'b0, 1'b0, 32'h00000005, 32'h00000003, 32'h00000008, 1'b0, 1'b0},
        {4'h0, 1'b1, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b1},
        {4'h1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 1'b0},
        {4'h1, 1'b1, 1'b1, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0},
        {4'h1, 1'b1, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
        {4'h2, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
        {4'h2, 1'b1, 1'b1, 32'h00000005, 32'hFFFFFFFF, 32'h00000005, 1'b1, 1'b0},
        {4'h2, 1'b1, 1'b0, 32'h00000003, 32'h00000004, 32'h00000007, 1'b0, 1'b0},
        {4'h3, 1'b1, 1'b0, 32'h00000000, 32'h12345678, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'h3, 1'b1, 1'b0, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 1'b1, 1'b1},
        {4'h3, 1'b0, 1'b1, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
        {4'h4, 1'b1, 1'b1, 32'h7FFFFFFF, 32'hABCDEF01, 32'h80000000, 1'b0, 1'b1},
        {4'h4, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
        {4'h8, 1'b0, 1'b0, 32'h00000003, 32'h0000000A, 32'h00000007, 1'b0, 1'b0},
        {4'h8, 1'b1, 1'b1, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b1},
        {4'h9, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0},
        {4'h9, 1'b1, 1'b1, 32'h00000006, 32'h00000005, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'h9, 1'b1, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
        {4'hA, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'hA, 1'b1, 1'b1, 32'h00000005, 32'h00000009, 32'h00000004, 1'b1, 1'b0},
        {4'hA, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 1'b0, 1'b1},
        {4'hB, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'hB, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000000, 32'h7FFFFFFF, 1'b1, 1'b1},
        {4'hC, 1'b1, 1'b1, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 1'b1},
        {4'hC, 1'b0, 1'b0, 32'h00000005, 32'h00000000, 32'hFFFFFFFA, 1'b0, 1'b0},
        {4'hC, 1'b1, 1'b1, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
        {4'h5, 1'b0, 1'b1, 32'h00000002, 32'h00000003, 32'h00000005, 1'b1, 1'b0},
        {4'hD, 1'b0, 1'b0, 32'h00000002, 32'h00000003, 32'h00000001, 1'b0, 1'b0}
    };

    function automatic logic [3:0] exp_cond(input logic [31:0] v, input logic ovb);
        return {v[31], !v[31] && (v != 32'h0), v == 32'h0, ovb};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // issue one operation; result/condition sampled mid-cycle, flags after the edge
    task automatic issue(input logic [3:0] op, input logic rec, input logic [31:0] a,
                         input logic [31:0] b, input logic vld, input logic clr);
        @(negedge clk);
        op_code      = op;
        op_record_ov = rec;
        opnd_a       = a;
        opnd_b       = b;
        op_valid     = vld;
        flag_clear   = clr;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid   = 1'b0;
        flag_clear = 1'b0;
        #1;
    endtask

    task automatic prep_ca(input logic c);
        issue(4'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1);
        if (c) begin
            issue(4'h1, 1'b0, 32'hFFFFFFFF, 32'h1, 1'b1, 1'b0);
        end
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 flags after reset", {29'h0, flag_so, flag_ov, flag_ca}, 32'h0);
        check("R10 zero result cond", {28'h0, rec_field}, 32'h2);
        rst_n = 1'b1;
        idle();

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic ov_new;
            v = VT[i];
            prep_ca(v.cin);
            issue(v.op, v.rec, v.a, v.b, 1'b1, 1'b0);
            ov_new = v.rec & v.ovf;
            check(v.op[3] ? "R2 result" : "R1 result", result, v.res);
            check("R10 cond field", {28'h0, rec_field}, {28'h0, exp_cond(v.res, ov_new)});
            idle();
            check((v.op[2:0] == 3'd0 || v.op[2:0] > 3'd4) ? "R4 carry kept" : "R3 carry written",
                  {31'h0, flag_ca}, {31'h0, v.ca});
            check(v.rec ? (v.ovf ? "R5 ov/so set" : "R6 ov cleared") : "R7 ov/so kept",
                  {30'h0, flag_so, flag_ov}, {30'h0, ov_new, ov_new});
        end

        // R6: SO sticky after a clean recording op
        prep_ca(1'b0);
        issue(4'h4, 1'b1, 32'h7FFFFFFF, 32'h0, 1'b0, 1'b0);
        issue(4'h0, 1'b1, 32'h7FFFFFFF, 32'h1, 1'b1, 1'b0);
        issue(4'h0, 1'b1, 32'h00000001, 32'h1, 1'b1, 1'b0);
        check("R10 cond bit0 uses new ov", {28'h0, rec_field}, 32'h4);
        idle();
        check("R6 so sticky ov cleared", {30'h0, flag_so, flag_ov}, 32'h2);

        // R7: non-recording op keeps OV=1, condition bit0 shows stored OV
        issue(4'h0, 1'b1, 32'h7FFFFFFF, 32'h1, 1'b1, 1'b0);
        issue(4'h1, 1'b0, 32'h00000002, 32'h3, 1'b1, 1'b0);
        check("R10 cond bit0 uses stored ov", {28'h0, rec_field}, 32'h5);
        idle();
        check("R7 ov so kept", {30'h0, flag_so, flag_ov}, 32'h3);

        // R8: no strobe, flags hold across several edges
        issue(4'h1, 1'b1, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        check("R8 hold without strobe", {29'h0, flag_so, flag_ov, flag_ca}, 32'h6);

        // R9: clear wins over an overflowing carry-writing issue
        issue(4'h1, 1'b1, 32'h80000000, 32'h80000000, 1'b1, 1'b1);
        idle();
        check("R9 clear priority", {29'h0, flag_so, flag_ov, flag_ca}, 32'h0);

        // R11: reset mid-run
        issue(4'h1, 1'b1, 32'h80000000, 32'h80000000, 1'b1, 1'b0);
        idle();
        check("R5 flags set before reset", {29'h0, flag_so, flag_ov, flag_ca}, 32'h7);
        rst_n = 1'b0;
        #1;
        check("R11 async reset", {29'h0, flag_so, flag_ov, flag_ca}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule